// File: doc/BRIEF.md
# Program-Load Entry and Autobaud Detector

This block decides, for a small microcontroller core, whether the part enters its program-load state and which loading path it then uses. While the external reset pin is held high and the program-store strobe pin is pulled low, the block arms. From then on it watches two inputs. One is the address-latch strobe, which serves as the parallel programming pulse. The other is the serial receive line. The first valid event on either input selects the loading path.

On the serial line the block waits for a carriage-return character (0x0D). The character must be sent as 8N1, least significant bit first, at one of four fixed rates. Bit 0 of 0x0D is a 1, so the start bit is the only low time before the first rising edge. The block times that low time with the system clock and picks the rate whose period lies within a tolerance of the measured time. It then samples the rest of the frame at mid-bit points at that rate and accepts the frame only if the character and the stop bit are correct.

Once a path is chosen, the selection stays latched until the reset pin is released. Releasing the reset pin always returns the block to its idle, unarmed state. All four pins cross into the clock domain through synchronizer stages.

Top module: `pload_detect`

## Requirements
- R1: After the system reset, load_mode, mode_locked, mode_serial and detect_stb are 0 and baud_sel is 00.
- R2: load_mode rises only when mcu_rst is 1 and psen_n is 0 at the same time, measured at the clock edge three cycles earlier (two synchronizer stages plus the state register). mcu_rst high alone or psen_n low alone leaves load_mode at 0.
- R3: While armed and unlocked, a rising edge on ale locks the parallel path. The block then shows mode_locked=1 and mode_serial=0 and raises detect_stb, even if a serial frame is in progress.
- R4: A start-bit low time within ±TOL_PCT percent (default 6) of CLK_HZ/rate cycles selects that rate. The baud_sel code is 00 for 9600, 01 for 2400, 10 for 1200 and 11 for 300 bit/s.
- R5: A low time that falls outside all four windows is ignored: no strobe is produced and the block goes back to waiting for the next falling edge.
- R6: After a rate is chosen, the eight data bits (LSB first) and the stop bit are sampled at mid-bit points. If the data bits are not 0x0D or the stop bit is 0, the frame is rejected with no strobe and the block goes back to waiting.
- R7: When a 0x0D frame with a good stop bit is accepted, the block shows mode_locked=1 and mode_serial=1 and sets baud_sel to the detected code. detect_stb is high for exactly one cycle, in the cycle where mode_locked rises.
- R8: Once the block is locked, further ale pulses and serial frames produce no strobe, and mode_serial and baud_sel stay unchanged until mcu_rst is released.
- R9: mcu_rst low for three consecutive cycles clears load_mode, the lock and the selection, and abandons any detection in progress. An interrupted frame leaves no strobe behind after the block is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| mcu_rst | input | 1 | External reset pin of the core, active high |
| psen_n | input | 1 | Program-store strobe pin; when low during reset, it requests load mode |
| ale | input | 1 | Address-latch strobe; its rising edge is the parallel load pulse |
| rxd | input | 1 | Serial receive line, idle high |
| load_mode | output | 1 | Load mode is armed |
| mode_locked | output | 1 | A loading path has been selected |
| mode_serial | output | 1 | 1 = serial path, 0 = parallel path (valid while locked) |
| baud_sel | output | 2 | Detected rate code: 00=9600, 01=2400, 10=1200, 11=300 |
| detect_stb | output | 1 | One-cycle pulse when a path is selected |

## Verification
The bench sends a start bit stretched by 5% and another stretched by 10%. A design with the wrong window edges would reject the first or accept the second at 9600. It also sends a 0x0F frame and a 0x0D frame with a zero stop bit. A design that trusted the start-bit timing alone would lock on either of them. After a lock, it sends a further ale pulse and a further serial frame; a design that did not latch its choice would strobe again or change baud_sel. A 300 bit/s frame is cut off by releasing the reset pin, and the block is then re-armed. A sampler that was not cleared on release would finish that stale frame and strobe.

// File: rtl/pload_pkg.sv
package pload_pkg;

    localparam int NUM_RATES = 4;
    localparam logic [7:0] CR_CHAR = 8'h0D;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_HUNT = 3'd1,
        ST_MEAS = 3'd2,
        ST_SAMP = 3'd3,
        ST_LOCK = 3'd4
    } det_state_e;

    // rate table indexed by the baud code
    function automatic int rate_bps(input int code);
        case (code)
            0:       return 9600;
            1:       return 2400;
            2:       return 1200;
            default: return 300;
        endcase
    endfunction

endpackage

// File: rtl/pload_sync.sv
module pload_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         sys_rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stg_d[s] = din;
        end else begin : g_next
            always_comb stg_d[s] = stg_q[s-1];
        end

        always_ff @(posedge clk or negedge sys_rst_n) begin
            if (!sys_rst_n) stg_q[s] <= RST_VAL;
            else            stg_q[s] <= stg_d[s];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pload_rate_match.sv
module pload_rate_match
    import pload_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TOL_PCT = 6,
    parameter int CNT_W   = 20
) (
    input  logic [CNT_W-1:0] meas_cnt,
    input  logic [1:0]       sel_code,
    output logic             hit,
    output logic [1:0]       hit_code,
    output logic [CNT_W-1:0] sel_period,
    output logic [CNT_W-1:0] sel_half
);

    logic [NUM_RATES-1:0] win;
    logic [CNT_W-1:0]     per_tab [NUM_RATES];

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
        localparam int PER = CLK_HZ / rate_bps(i);
        localparam int TOL = (PER * TOL_PCT) / 100;
        localparam int LO  = PER - TOL;
        localparam int HI  = PER + TOL;

        assign per_tab[i] = CNT_W'(PER);
        assign win[i]     = (meas_cnt >= CNT_W'(LO)) && (meas_cnt <= CNT_W'(HI));
    end

    always_comb begin
        hit      = |win;
        hit_code = 2'd0;
        for (int i = NUM_RATES - 1; i >= 0; i--) begin
            if (win[i]) hit_code = 2'(i);
        end
        sel_period = per_tab[sel_code];
        sel_half   = per_tab[sel_code] >> 1;
    end

endmodule

// File: rtl/pload_frame_sampler.sv
module pload_frame_sampler
    import pload_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [CNT_W-1:0] half_per,
    input  logic [CNT_W-1:0] full_per,
    input  logic             rx,
    output logic             done,
    output logic             match
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] timer;
        logic [3:0]       idx;
        logic [8:0]       shreg;
        logic             done;
        logic             match;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d      = samp_q;
        samp_d.done = 1'b0;
        if (abort) begin
            samp_d.busy = 1'b0;
        end else if (start) begin
            samp_d.busy  = 1'b1;
            samp_d.timer = half_per - CNT_W'(1);
            samp_d.idx   = 4'd0;
        end else if (samp_q.busy) begin
            if (samp_q.timer == '0) begin
                samp_d.shreg = {rx, samp_q.shreg[8:1]};
                if (samp_q.idx == 4'd8) begin
                    samp_d.busy  = 1'b0;
                    samp_d.done  = 1'b1;
                    samp_d.match = (samp_q.shreg[8:1] == CR_CHAR) && rx;
                end else begin
                    samp_d.idx   = samp_q.idx + 4'd1;
                    samp_d.timer = full_per - CNT_W'(1);
                end
            end else begin
                samp_d.timer = samp_q.timer - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) samp_q <= '0;
        else            samp_q <= samp_d;
    end

    assign done  = samp_q.done;
    assign match = samp_q.match;

endmodule

// File: rtl/pload_detect.sv
module pload_detect
    import pload_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int TOL_PCT     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       sys_rst_n,
    input  logic       mcu_rst,
    input  logic       psen_n,
    input  logic       ale,
    input  logic       rxd,
    output logic       load_mode,
    output logic       mode_locked,
    output logic       mode_serial,
    output logic [1:0] baud_sel,
    output logic       detect_stb
);

    localparam int SLOW_PER = CLK_HZ / 300;
    localparam int CNT_W    = $clog2(2 * SLOW_PER + 2);

    typedef struct packed {
        det_state_e       state;
        logic             rx_prev;
        logic             ale_prev;
        logic [CNT_W-1:0] cnt;
        logic             serial;
        logic [1:0]       baud;
        logic             stb;
    } det_t;

    det_t det_d, det_q;

    logic [3:0]       pins_s;
    logic             rst_s, psen_s, ale_s, rx_s;
    logic             m_hit;
    logic [1:0]       m_code, rate_sel;
    logic [CNT_W-1:0] per_full, per_half;
    logic             samp_start, samp_abort, samp_done, samp_match;
    logic             ale_rise, rx_fall;

    pload_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1010)
    ) u_sync (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .din       ({rxd, ale, psen_n, mcu_rst}),
        .dout      (pins_s)
    );

    assign rst_s  = pins_s[0];
    assign psen_s = pins_s[1];
    assign ale_s  = pins_s[2];
    assign rx_s   = pins_s[3];

    assign rate_sel = (det_q.state == ST_SAMP) ? det_q.baud : m_code;

    pload_rate_match #(
        .CLK_HZ  (CLK_HZ),
        .TOL_PCT (TOL_PCT),
        .CNT_W   (CNT_W)
    ) u_match (
        .meas_cnt   (det_q.cnt),
        .sel_code   (rate_sel),
        .hit        (m_hit),
        .hit_code   (m_code),
        .sel_period (per_full),
        .sel_half   (per_half)
    );

    pload_frame_sampler #(
        .CNT_W (CNT_W)
    ) u_samp (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .abort     (samp_abort),
        .start     (samp_start),
        .half_per  (per_half),
        .full_per  (per_full),
        .rx        (rx_s),
        .done      (samp_done),
        .match     (samp_match)
    );

    assign ale_rise = ale_s && !det_q.ale_prev;
    assign rx_fall  = !rx_s && det_q.rx_prev;

    always_comb begin
        det_d          = det_q;
        det_d.stb      = 1'b0;
        det_d.rx_prev  = rx_s;
        det_d.ale_prev = ale_s;
        samp_start     = 1'b0;
        samp_abort     = 1'b0;

        if (!rst_s) begin
            det_d.state  = ST_OFF;
            det_d.serial = 1'b0;
            det_d.baud   = 2'd0;
            det_d.cnt    = '0;
            samp_abort   = 1'b1;
        end else begin
            case (det_q.state)
                ST_OFF: begin
                    if (!psen_s) det_d.state = ST_HUNT;
                end
                ST_HUNT, ST_MEAS, ST_SAMP: begin
                    if (ale_rise) begin
                        det_d.state  = ST_LOCK;
                        det_d.serial = 1'b0;
                        det_d.baud   = 2'd0;
                        det_d.stb    = 1'b1;
                        samp_abort   = 1'b1;
                    end else if (det_q.state == ST_HUNT) begin
                        if (rx_fall) begin
                            det_d.state = ST_MEAS;
                            det_d.cnt   = CNT_W'(1);
                        end
                    end else if (det_q.state == ST_MEAS) begin
                        if (!rx_s) begin
                            if (det_q.cnt != '1) det_d.cnt = det_q.cnt + CNT_W'(1);
                        end else if (m_hit) begin
                            det_d.state = ST_SAMP;
                            det_d.baud  = m_code;
                            samp_start  = 1'b1;
                        end else begin
                            det_d.state = ST_HUNT;
                        end
                    end else begin
                        if (samp_done) begin
                            if (samp_match) begin
                                det_d.state  = ST_LOCK;
                                det_d.serial = 1'b1;
                                det_d.stb    = 1'b1;
                            end else begin
                                det_d.state = ST_HUNT;
                                det_d.baud  = 2'd0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            det_q          <= '0;
            det_q.state    <= ST_OFF;
            det_q.rx_prev  <= 1'b1;
        end else begin
            det_q <= det_d;
        end
    end

    assign load_mode   = (det_q.state != ST_OFF);
    assign mode_locked = (det_q.state == ST_LOCK);
    assign mode_serial = det_q.serial;
    assign baud_sel    = det_q.baud;
    assign detect_stb  = det_q.stb;

endmodule

// File: rtl/pload_detect_chk.sv
module pload_detect_chk (
    input logic       clk,
    input logic       sys_rst_n,
    input logic       mcu_rst,
    input logic       psen_n,
    input logic       load_mode,
    input logic       mode_locked,
    input logic       mode_serial,
    input logic [1:0] baud_sel,
    input logic       detect_stb
);

    // R2: arming traces back to both pins, three edges earlier
    assert_arm_cond_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(load_mode) |-> ($past(mcu_rst, 3) && !$past(psen_n, 3)));

    // R3: a lock can only exist inside load mode
    assert_lock_in_mode_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        mode_locked |-> load_mode);

    // R7: strobe lasts one cycle
    assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        detect_stb |=> !detect_stb);

    // R7: strobe coincides with the lock rising
    assert_stb_lock_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        detect_stb |-> $rose(mode_locked));

    // R8: selection frozen while locked
    assert_locked_stable_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (mode_locked && $past(mode_locked)) |-> ($stable(mode_serial) && $stable(baud_sel)));

    // R9: reset pin released for three cycles clears load mode
    assert_release_clears_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!mcu_rst && !$past(mcu_rst) && !$past(mcu_rst, 2)) |=> !load_mode);

endmodule

bind pload_detect pload_detect_chk u_chk (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .mcu_rst     (mcu_rst),
    .psen_n      (psen_n),
    .load_mode   (load_mode),
    .mode_locked (mode_locked),
    .mode_serial (mode_serial),
    .baud_sel    (baud_sel),
    .detect_stb  (detect_stb)
);

// File: tb/tb_pload_detect.sv
`timescale 1ns/1ps
module tb_pload_detect;

    localparam int CLK_HZ = 192000;
    localparam int P9600  = CLK_HZ / 9600;
    localparam int P2400  = CLK_HZ / 2400;
    localparam int P1200  = CLK_HZ / 1200;
    localparam int P300   = CLK_HZ / 300;

    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       mcu_rst = 1'b0;
    logic       psen_n = 1'b1;
    logic       ale = 1'b0;
    logic       rxd = 1'b1;
    logic       load_mode, mode_locked, mode_serial, detect_stb;
    logic [1:0] baud_sel;

    typedef struct {
        logic       serial;
        logic [1:0] baud;
    } exp_t;

    exp_t expq[$];
    int   total = 0;
    int   bad   = 0;

    always #4 clk = ~clk;

    pload_detect #(.CLK_HZ(CLK_HZ)) dut (
        .clk         (clk),
        .sys_rst_n   (sys_rst_n),
        .mcu_rst     (mcu_rst),
        .psen_n      (psen_n),
        .ale         (ale),
        .rxd         (rxd),
        .load_mode   (load_mode),
        .mode_locked (mode_locked),
        .mode_serial (mode_serial),
        .baud_sel    (baud_sel),
        .detect_stb  (detect_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_det(input logic serial, input logic [1:0] baud);
        exp_t e;
        e.serial = serial;
        e.baud   = baud;
        expq.push_back(e);
    endtask

    task automatic arm();
        mcu_rst = 1'b1;
        wait_cyc(2);
        psen_n = 1'b0;
        wait_cyc(6);
    endtask

    task automatic release_rst();
        psen_n  = 1'b1;
        mcu_rst = 1'b0;
        wait_cyc(6);
    endtask

    task automatic pulse_ale();
        ale = 1'b1;
        wait_cyc(4);
        ale = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_frame(input int bit_cyc, input int start_cyc,
                              input logic [7:0] data, input logic stop);
        rxd = 1'b0;
        wait_cyc(start_cyc);
        for (int i = 0; i < 8; i++) begin
            rxd = data[i];
            wait_cyc(bit_cyc);
        end
        rxd = stop;
        wait_cyc(bit_cyc);
        rxd = 1'b1;
        wait_cyc(2 * bit_cyc + 10);
    endtask

    // monitor: every strobe must match a queued expectation
    always @(negedge clk) begin
        if (sys_rst_n && detect_stb) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5/R6/R8/R9", "unexpected detect_stb", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(mode_serial == e.serial, "R3/R7", "mode_serial", mode_serial, e.serial);
                chk(mode_locked == 1'b1, "R7", "mode_locked with strobe", mode_locked, 1);
                if (e.serial)
                    chk(baud_sel == e.baud, "R4", "baud_sel", baud_sel, e.baud);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        chk(load_mode == 0 && mode_locked == 0 && detect_stb == 0, "R1", "flags in reset",
            {load_mode, mode_locked, detect_stb}, 0);
        sys_rst_n = 1'b1;
        wait_cyc(4);
        chk(load_mode == 0 && mode_serial == 0 && baud_sel == 0, "R1", "after reset",
            {load_mode, mode_serial, baud_sel}, 0);

        // R2: one condition alone does not arm
        mcu_rst = 1'b1;
        wait_cyc(10);
        chk(load_mode == 0, "R2", "reset pin alone", load_mode, 0);
        mcu_rst = 1'b0;
        psen_n  = 1'b0;
        wait_cyc(10);
        chk(load_mode == 0, "R2", "strobe low alone", load_mode, 0);
        psen_n = 1'b1;
        wait_cyc(4);
        arm();
        chk(load_mode == 1, "R2", "both conditions arm", load_mode, 1);

        // R3: parallel pulse
        expect_det(1'b0, 2'd0);
        pulse_ale();
        chk(mode_locked == 1 && mode_serial == 0, "R3", "parallel lock",
            {mode_locked, mode_serial}, 2);
        // R8: serial frame after parallel lock has no effect
        send_frame(P9600, P9600, 8'h0D, 1'b1);
        chk(mode_serial == 0 && mode_locked == 1, "R8", "lock kept after frame",
            {mode_locked, mode_serial}, 2);

        // R9: release clears
        release_rst();
        chk(load_mode == 0 && mode_locked == 0, "R9", "release clears",
            {load_mode, mode_locked}, 0);

        // R4/R7: each rate
        arm();
        expect_det(1'b1, 2'd0);
        send_frame(P9600, P9600, 8'h0D, 1'b1);
        // R8: ale after serial lock ignored
        pulse_ale();
        chk(mode_serial == 1 && baud_sel == 0, "R8", "ale after serial lock",
            {mode_serial, baud_sel}, 4);
        release_rst();

        arm();
        expect_det(1'b1, 2'd1);
        send_frame(P2400, P2400, 8'h0D, 1'b1);
        release_rst();

        arm();
        expect_det(1'b1, 2'd2);
        send_frame(P1200, P1200, 8'h0D, 1'b1);
        release_rst();

        arm();
        expect_det(1'b1, 2'd3);
        send_frame(P300, P300, 8'h0D, 1'b1);
        release_rst();

        // R5: out-of-window low pulses, then +10% frame, then +5% frame
        arm();
        rxd = 1'b0;
        wait_cyc(50);
        rxd = 1'b1;
        wait_cyc(40);
        chk(load_mode == 1 && mode_locked == 0, "R5", "odd pulse ignored",
            {load_mode, mode_locked}, 2);
        send_frame(P9600 + P9600 / 10, P9600 + P9600 / 10, 8'h0D, 1'b1);
        chk(mode_locked == 0, "R5", "10% slow frame ignored", mode_locked, 0);
        expect_det(1'b1, 2'd0);
        send_frame(P9600 + P9600 / 20, P9600 + P9600 / 20, 8'h0D, 1'b1);
        chk(mode_locked == 1 && baud_sel == 0, "R4", "5% slow frame accepted",
            {mode_locked, baud_sel}, 4);
        release_rst();

        // R6: wrong character, bad stop bit, then good frame
        arm();
        send_frame(P1200, P1200, 8'h0F, 1'b1);
        chk(mode_locked == 0, "R6", "wrong char rejected", mode_locked, 0);
        send_frame(P2400, P2400, 8'h0D, 1'b0);
        chk(mode_locked == 0, "R6", "bad stop rejected", mode_locked, 0);
        chk(load_mode == 1, "R6", "still waiting", load_mode, 1);
        expect_det(1'b1, 2'd1);
        send_frame(P2400, P2400, 8'h0D, 1'b1);
        release_rst();

        // R9: abort mid-frame at 300
        arm();
        rxd = 1'b0;
        wait_cyc(P300);
        rxd = 1'b1;
        wait_cyc(2 * P300);
        release_rst();
        chk(load_mode == 0, "R9", "abort clears load_mode", load_mode, 0);
        arm();
        wait_cyc(8 * P300);
        chk(mode_locked == 0, "R9", "no lock from stale frame", mode_locked, 0);
        release_rst();

        wait_cyc(20);
        chk(expq.size() == 0, "R7", "all detections seen", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule